// File: doc/BRIEF.md
# Iterative Shift Unit

This block shifts a 32-bit word left or right by a variable amount. It does this with a small step datapath that it uses once per clock, not with a full barrel network. A caller presents the word, an 8-bit amount, the direction, the fill rule, the step mode and the amount limit, then pulses `start`. The unit loads the amount into down-counters and moves the word one step per cycle. It then raises `done` for one cycle and keeps the result on `data_out` until the next accepted start.

There are two step modes. Single mode moves one bit per cycle. Mixed mode first takes the fine steps of one bit each, from the amount modulo four. It then takes coarse steps of four bits each, from the amount divided by four. Amounts may exceed the word width. The extra steps keep pushing in zeros, or copies of the sign bit for an arithmetic right shift. The limit control keeps only the low five amount bits, so the worst-case run time is bounded.

Top module: `iter_shift_unit`

## Requirements
- R1: After a cycle with `rst_n` low, `busy` and `done` are 0 and `data_out` is all zeros.
- R2: `start` is accepted only while `busy` is 0. In the cycle after acceptance, `busy` is 1. The word, direction and fill rule are captured at acceptance.
- R3: With `mode` = 0 (single steps), `done` rises E+1 cycles after the accepting edge, where E is the effective amount.
- R4: With `mode` = 1 (mixed steps), `done` rises (E mod 4) + floor(E/4) + 1 cycles after the accepting edge.
- R5: `dir` = 0 shifts left and fills with zeros. `dir` = 1 shifts right and fills with zeros, or with bit 31 of the input word when `arith` = 1. `arith` has no effect on a left shift. The final word equals a single shift by E in both modes.
- R6: With `limit` = 1, E is `count[4:0]` (0 to 31). With `limit` = 0, E is the full 8-bit `count`. An E of 32 or more yields all zeros, or all copies of the sign for an arithmetic right shift.
- R7: When E is 0, `done` rises one cycle after the accepting edge and `data_out` equals the input word unchanged.
- R8: A `start` pulse while `busy` is 1 changes neither the result nor the completion time of the operation in flight.
- R9: `done` is high for exactly one cycle, in the same cycle that `busy` falls. `data_out` then stays constant until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request to begin a shift; ignored while busy |
| data_in | input | 32 | Word to be shifted |
| count | input | 8 | Shift amount |
| dir | input | 1 | 0 = left, 1 = right |
| arith | input | 1 | 1 = sign fill on right shift |
| mode | input | 1 | 0 = single-bit steps, 1 = fine then coarse steps |
| limit | input | 1 | 1 = use only the low five amount bits |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| data_out | output | 32 | Shifted word, held after completion |

## Verification
Every state error in this block shows up at the ports when the operation finishes. A miscounted step counter moves the `done` pulse earlier or later by the error, or leaves `done` missing. The final word also ends up shifted by the wrong amount. A wrong fill bit or a wrong coarse step width corrupts the top or bottom bits of `data_out`, and this is visible in the `done` cycle. A reload caused by a late start stretches the latency by many cycles, so the bench checks both the completion cycle and the final word for every operation.

// File: rtl/iter_shift_pkg.sv
// Shared sizing and step-mode encoding for the iterative shift unit.
// Assumes COARSE_STEP is a power of two that is smaller than DATA_W.
package iter_shift_pkg;
    parameter int DATA_W      = 32;  // word width
    parameter int CNT_W       = 8;   // width of the shift amount input
    parameter int LIM_W       = 5;   // amount bits kept when limited
    parameter int COARSE_STEP = 4;   // bits moved by one coarse step

    typedef enum logic {
        STEP_SINGLE = 1'b0,
        STEP_MIXED  = 1'b1
    } step_mode_e;
endpackage

// File: rtl/ishf_count_plan.sv
// Splits the requested amount into fine and coarse iteration counts.
// Assumes COARSE_STEP is a power of two; the fine count holds the low bits in mixed mode.
module ishf_count_plan
    import iter_shift_pkg::*;
#(
    parameter int CW     = CNT_W,
    parameter int LW     = LIM_W,
    parameter int CSTEP  = COARSE_STEP,
    localparam int FW    = $clog2(CSTEP),
    localparam int CRS_W = CW - FW
) (
    input  logic [CW-1:0]    count,
    input  logic             mode,
    input  logic             limit,
    output logic [CW-1:0]    fine_load,
    output logic [CRS_W-1:0] coarse_load
);
    logic [CW-1:0] eff;

    // Apply the amount limit, then divide the work between the two step kinds.
    always_comb begin
        eff = count;
        if (limit) begin
            eff = CW'(count[LW-1:0]);
        end
        if (step_mode_e'(mode) == STEP_MIXED) begin
            fine_load   = CW'(eff[FW-1:0]);
            coarse_load = eff[CW-1:FW];
        end else begin
            fine_load   = eff;
            coarse_load = '0;
        end
    end
endmodule

// File: rtl/ishf_step_unit.sv
// One iteration of the shift: a 1-bit move or a coarse move, in either direction.
// Assumes the caller holds the direction and fill rule stable for the whole run.
module ishf_step_unit
    import iter_shift_pkg::*;
#(
    parameter int DW    = DATA_W,
    parameter int CSTEP = COARSE_STEP
) (
    input  logic [DW-1:0] cur,
    input  logic          dir_right,
    input  logic          arith,
    input  logic          coarse,
    output logic [DW-1:0] nxt
);
    logic          fill;
    logic [DW-1:0] one_step;
    logic [DW-1:0] big_step;

    // Work out both step widths and pick the one the controller asks for.
    always_comb begin
        fill = arith & dir_right & cur[DW-1];
        if (dir_right) begin
            one_step = {fill, cur[DW-1:1]};
            big_step = {{CSTEP{fill}}, cur[DW-1:CSTEP]};
        end else begin
            one_step = {cur[DW-2:0], 1'b0};
            big_step = {cur[DW-1-CSTEP:0], {CSTEP{1'b0}}};
        end
        nxt = coarse ? big_step : one_step;
    end
endmodule

// File: rtl/ishf_ctrl.sv
// Run control: accepts a start when idle and runs the fine steps, then the coarse steps.
// After that it spends one completion cycle that drops busy and pulses done.
// Assumes the load values are valid in the cycle that start is high.
module ishf_ctrl
    import iter_shift_pkg::*;
#(
    parameter int CW     = CNT_W,
    parameter int CSTEP  = COARSE_STEP,
    localparam int FW    = $clog2(CSTEP),
    localparam int CRS_W = CW - FW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CW-1:0]    fine_load,
    input  logic [CRS_W-1:0] coarse_load,
    output logic             busy,
    output logic             done,
    output logic             load,
    output logic             step_en,
    output logic             step_coarse,
    output logic [CW-1:0]    fine_q,
    output logic [CRS_W-1:0] coarse_q
);
    logic fine_left;
    logic coarse_left;

    // Decode the remaining work and the strobes for the datapath.
    always_comb begin
        fine_left   = (fine_q != '0);
        coarse_left = (coarse_q != '0);
        load        = start & ~busy;
        step_en     = busy & (fine_left | coarse_left);
        step_coarse = ~fine_left;
    end

    // Counter and handshake state: load, count down, then finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            done     <= 1'b0;
            fine_q   <= '0;
            coarse_q <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy     <= 1'b1;
                    fine_q   <= fine_load;
                    coarse_q <= coarse_load;
                end
            end else if (fine_left) begin
                fine_q <= fine_q - 1'b1;
            end else if (coarse_left) begin
                coarse_q <= coarse_q - 1'b1;
            end else begin
                busy <= 1'b0;
                done <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/iter_shift_unit.sv
// Top of the iterative shift unit. It holds the working word and the latched
// direction and fill rule, and it ties together the planner, the controller and the step logic.
// Assumes a synchronous active-low reset and a single clock.
module iter_shift_unit
    import iter_shift_pkg::*;
#(
    parameter int DW     = DATA_W,
    parameter int CW     = CNT_W,
    parameter int LW     = LIM_W,
    parameter int CSTEP  = COARSE_STEP,
    localparam int FW    = $clog2(CSTEP),
    localparam int CRS_W = CW - FW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] data_in,
    input  logic [CW-1:0] count,
    input  logic          dir,
    input  logic          arith,
    input  logic          mode,
    input  logic          limit,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] data_out
);
    logic [CW-1:0]    fine_load;
    logic [CRS_W-1:0] coarse_load;
    logic [CW-1:0]    fine_q;
    logic [CRS_W-1:0] coarse_q;
    logic             load;
    logic             step_en;
    logic             step_coarse;
    logic [DW-1:0]    word_q;
    logic [DW-1:0]    word_nxt;
    logic             dir_q;
    logic             arith_q;

    ishf_count_plan #(.CW(CW), .LW(LW), .CSTEP(CSTEP)) u_plan (
        .count       (count),
        .mode        (mode),
        .limit       (limit),
        .fine_load   (fine_load),
        .coarse_load (coarse_load)
    );

    ishf_ctrl #(.CW(CW), .CSTEP(CSTEP)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .fine_load   (fine_load),
        .coarse_load (coarse_load),
        .busy        (busy),
        .done        (done),
        .load        (load),
        .step_en     (step_en),
        .step_coarse (step_coarse),
        .fine_q      (fine_q),
        .coarse_q    (coarse_q)
    );

    ishf_step_unit #(.DW(DW), .CSTEP(CSTEP)) u_step (
        .cur       (word_q),
        .dir_right (dir_q),
        .arith     (arith_q),
        .coarse    (step_coarse),
        .nxt       (word_nxt)
    );

    // Working word and latched controls: capture at acceptance, update on each step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q  <= '0;
            dir_q   <= 1'b0;
            arith_q <= 1'b0;
        end else if (load) begin
            word_q  <= data_in;
            dir_q   <= dir;
            arith_q <= arith;
        end else if (step_en) begin
            word_q <= word_nxt;
        end
    end

    assign data_out = word_q;
endmodule

// File: rtl/ishf_checker.sv
// Temporal checks on the handshake and counters of the iterative shift unit.
// It is attached to the top with the bind below and reads the ports and the run counters.
module ishf_checker #(
    parameter int DW    = 32,
    parameter int CW    = 8,
    parameter int LW    = 5,
    parameter int CRS_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [CW-1:0]    count,
    input logic             limit,
    input logic             busy,
    input logic             done,
    input logic [DW-1:0]    data_out,
    input logic [CW-1:0]    fine_q,
    input logic [CRS_W-1:0] coarse_q
);
    logic [CW:0]   rem;
    logic [CW-1:0] eff;

    // Total steps still owed and the effective amount that is requested.
    always_comb begin
        rem = {1'b0, fine_q} + (CW+1)'(coarse_q);
        eff = limit ? CW'(count[LW-1:0]) : count;
    end

    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);  // R2

    AST_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ((rem < $past(rem)) || (rem == '0)));  // R8

    AST_ZERO_QUICK: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && eff == '0) |=> busy ##1 done);  // R7

    AST_DONE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);  // R9

    AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));  // R9

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(data_out));  // R9
endmodule

bind iter_shift_unit ishf_checker #(
    .DW(DW), .CW(CW), .LW(LW), .CRS_W(CRS_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .count    (count),
    .limit    (limit),
    .busy     (busy),
    .done     (done),
    .data_out (data_out),
    .fine_q   (fine_q),
    .coarse_q (coarse_q)
);

// File: tb/iter_shift_unit_tb.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each comparing results with a computed model.
module iter_shift_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] data_in = '0;
    logic [7:0]  count = '0;
    logic        dir = 1'b0;
    logic        arith = 1'b0;
    logic        mode = 1'b0;
    logic        limit = 1'b0;
    logic        busy;
    logic        done;
    logic [31:0] data_out;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;  // 250 MHz

    iter_shift_unit u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .data_in(data_in),
        .count(count), .dir(dir), .arith(arith), .mode(mode), .limit(limit),
        .busy(busy), .done(done), .data_out(data_out)
    );

    function automatic int eff_of(input logic [7:0] c, input logic lim);
        return lim ? int'(c[4:0]) : int'(c);
    endfunction

    function automatic logic [31:0] model(input logic [31:0] d, input int e,
                                          input logic rt, input logic ar);
        if (!rt) return (e >= 32) ? 32'h0 : (d << e);
        if (ar)  return (e >= 32) ? {32{d[31]}} : 32'($signed(d) >>> e);
        return (e >= 32) ? 32'h0 : (d >> e);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Reset state of the outputs.
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 busy", 32'(busy), 32'd0);
        chk("R1 done", 32'(done), 32'd0);
        chk("R1 data_out", data_out, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // One full operation with checks on start, latency, result, pulse and hold.
    task automatic t_op(input string req, input logic [31:0] d, input logic [7:0] c,
                        input logic rt, input logic ar, input logic md, input logic lim,
                        input logic inject);
        int e = eff_of(c, lim);
        int steps = md ? (e % 4) + (e / 4) : e;
        int cyc = 0;
        logic [31:0] exp = model(d, e, rt, ar);
        logic [31:0] held;
        data_in = d; count = c; dir = rt; arith = ar; mode = md; limit = lim; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk({"R2 busy after start ", req}, 32'(busy), 32'd1);
        while (!done && cyc < 400) begin
            @(negedge clk);
            cyc++;
            if (inject && cyc == 3) begin
                // R8: a late start carrying different operands
                start = 1'b1; data_in = ~d; count = 8'd0; dir = ~rt; mode = ~md;
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        chk({"R3/R4 latency ", req}, 32'(cyc), 32'(steps + 1));
        chk({"R5 result ", req}, data_out, exp);
        chk({"R9 busy low at done ", req}, 32'(busy), 32'd0);
        held = data_out;
        repeat (4) @(negedge clk);
        chk({"R9 done single pulse ", req}, 32'(done), 32'd0);
        chk({"R9 result held ", req}, data_out, held);
    endtask

    task automatic t_single_mode();
        t_op("R3 left",        32'h0000_00F1, 8'd5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        t_op("R3 right logic", 32'h8000_0010, 8'd7, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        t_op("R3 right arith", 32'h8000_0010, 8'd7, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        t_op("R5 arith ignored left", 32'h8000_0001, 8'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_mixed_mode();
        t_op("R4 left 13",      32'h1234_5678, 8'd13, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        t_op("R4 arith 22",     32'hF000_0000, 8'd22, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
        t_op("R4 coarse only",  32'hA5A5_A5A5, 8'd4,  1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        t_op("R4 fine only",    32'hA5A5_A5A5, 8'd3,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_zero_count();
        t_op("R7 zero single", 32'hDEAD_BEEF, 8'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        t_op("R7 zero mixed",  32'h0BAD_F00D, 8'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_full_range();
        t_op("R6 legacy 255 arith", 32'h8000_0001, 8'd255, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        t_op("R6 legacy 255 mixed", 32'hFFFF_FFFF, 8'd255, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        t_op("R6 legacy 33 left",   32'hFFFF_FFFF, 8'd33,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_limited();
        t_op("R6 limit 255",   32'h0000_0001, 8'd255, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        t_op("R6 limit 40",    32'h0000_FF00, 8'd40,  1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
        t_op("R6 limit 32",    32'h1357_9BDF, 8'd32,  1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_start_while_busy();
        t_op("R8 single", 32'h0000_0F0F, 8'd20, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        t_op("R8 mixed",  32'h8F00_0000, 8'd21, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
    endtask

    initial begin
        #(2_000_000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_single_mode();
        t_mixed_mode();
        t_zero_count();
        t_full_range();
        t_limited();
        t_start_while_busy();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule